// File: doc/BRIEF.md
# Replay Field Capture Sequencer

This block decides, one video field at a time, what happens to a circular store of field slots kept in external memory. On every field-sync strobe it samples its controls and settles the coming field. It decides whether the incoming field is written, which slot receives it, and whether a recorded sequence is being played back. During playback it also decides which slot is read and how many field periods each stored picture stays on screen. Moving the pixels, the memory timing and the video decoding belong to other blocks, which take the slot numbers and the write strobe from here.

Capture runs in three steps. Capture ready is armed: memory is cleared, then refilled with one field out of every N, overwriting the oldest slot once the store is full. Dropping the save/clear control freezes the store. A replay command then plays the frozen sequence from the oldest slot to the newest. Playback can be slowed by powers of two relative to the acquire rate. Arming is refused while any picture-in-picture window is switched on.

Top module: `fld_replay_seq`

## Requirements
- R1: While capture ready is active, the decimation ratio N is 4, 6, 8 or 10 for acquire codes 0, 1, 2 and 3. The arming field and every Nth field after it are written (wr_en high for that field period), and the others are not.
- R2: The first field written after arming goes to slot 0. Each later write uses the next slot, wrapping modulo SLOTS, so the oldest field is overwritten.
- R3: A strobe with save_clr = 0 freezes the store. No write happens in that field or later ones until capture ready is armed again, and the stored sequence is kept.
- R4: A strobe with save_clr = 1 while no_win = 0 is ignored. Nothing is cleared or written, and the stored sequence is kept.
- R5: A strobe with replay_go = 1, store frozen, no replay running and at least one valid slot starts playback. The first slot read is slot 0 if the store never wrapped, and otherwise the oldest slot (the next one to be written).
- R6: Each slot is held for N << P field periods. N is the ratio of the last armed acquire code, and P is the playback code (0..3, for 1x, 1/2, 1/4 and 1/8) sampled when playback starts.
- R7: Playback visits only the valid slots, in write order. replay_active falls at the strobe that ends the newest slot's hold, so a replay lasts valid_count × N << P field periods.
- R8: Changes of the acquire code while capture ready is inactive have no effect on later playback.
- R9: Controls are sampled only on the strobe. No output changes in a cycle without a strobe.
- R10: After reset, replay_active, wr_en and wr_busy are 0, the store holds no valid slot, and a replay command is ignored.
- R11: wr_busy rises at the arming strobe. It falls at the strobe that completes the first field written after arming, or at a freeze, whichever comes first.
- R12: Arming capture ready during playback stops the playback at that strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fld_strobe | input | 1 | One-cycle pulse at each field boundary |
| acq_code | input | 2 | Decimation select (1 of 4/6/8/10) |
| pb_code | input | 2 | Playback slow-down select (1x to 1/8) |
| save_clr | input | 1 | 1 = clear and refill, 0 = freeze |
| no_win | input | 1 | 1 when every picture window is disabled |
| replay_go | input | 1 | 1 = start playback, 0 = no action |
| wr_en | output | 1 | Current field is being stored |
| wr_slot | output | $clog2(SLOTS) | Slot receiving the current field |
| rd_slot | output | $clog2(SLOTS) | Slot shown during playback |
| replay_active | output | 1 | Playback in progress |
| wr_busy | output | 1 | Requested write not yet complete |

## Verification
The assertions assume fld_strobe is a clean single-cycle pulse that never repeats on back-to-back cycles. They also assume the controls only matter on that cycle. The bench keeps to this by raising the strobe for one cycle every few clocks and scrambling all the other controls in the idle cycles between strobes. Playback also relies on the acquire code that was latched while capture was armed. For that reason the bench changes the code while the store is frozen, and checks replay lengths against the ratio that was armed.

// File: rtl/frs_pkg.sv
package frs_pkg;
  localparam int HOLD_W = 7;
  typedef logic [1:0] code_t;

  function automatic logic [3:0] acq_ratio(input code_t c);
    return 4'd4 + {1'b0, c, 1'b0};
  endfunction

  function automatic logic [HOLD_W-1:0] hold_len(input code_t a, input code_t p);
    return {3'b000, acq_ratio(a)} << p;
  endfunction
endpackage

// File: rtl/frs_capture.sv
module frs_capture
  import frs_pkg::*;
#(
  parameter int SLOTS = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      fld_strobe,
  input  logic                      save_clr,
  input  logic                      no_win,
  input  code_t                     acq_code,
  output logic                      arm_next,
  output logic                      armed,
  output logic                      wr_en,
  output logic [$clog2(SLOTS)-1:0]  wr_slot,
  output logic [$clog2(SLOTS)-1:0]  wptr,
  output logic [$clog2(SLOTS+1)-1:0] vcount,
  output code_t                     acq_lat,
  output logic                      wr_busy
);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int CNT_W  = $clog2(SLOTS + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(SLOTS);

  logic [3:0]        dec_q;
  logic [3:0]        base_dec;
  logic [3:0]        ratio;
  logic [3:0]        dec_nxt;
  logic [SLOT_W-1:0] base_ptr;
  logic [CNT_W-1:0]  base_cnt;
  logic              take_field;
  logic              clr_evt;

  function automatic logic [SLOT_W-1:0] slot_inc(input logic [SLOT_W-1:0] s);
    return (32'(s) == SLOTS - 1) ? '0 : s + 1'b1;
  endfunction

  always_comb begin
    arm_next   = save_clr & no_win;
    clr_evt    = fld_strobe & arm_next & ~armed;
    base_dec   = armed ? dec_q : 4'd0;
    base_ptr   = armed ? wptr : '0;
    base_cnt   = armed ? vcount : '0;
    ratio      = acq_ratio(acq_code);
    take_field = (base_dec == 4'd0);
    dec_nxt    = (base_dec >= ratio - 4'd1) ? 4'd0 : base_dec + 4'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      dec_q   <= '0;
      wptr    <= '0;
      vcount  <= '0;
      wr_en   <= 1'b0;
      wr_slot <= '0;
      acq_lat <= '0;
      wr_busy <= 1'b0;
    end else if (fld_strobe) begin
      armed   <= arm_next;
      wr_busy <= arm_next & (~armed | (wr_busy & ~wr_en));
      if (arm_next) begin
        acq_lat <= acq_code;
        dec_q   <= dec_nxt;
        wr_en   <= take_field;
        if (take_field) begin
          wr_slot <= base_ptr;
          wptr    <= slot_inc(base_ptr);
          vcount  <= (base_cnt == FULL) ? FULL : base_cnt + 1'b1;
        end else begin
          wptr    <= base_ptr;
          vcount  <= base_cnt;
        end
      end else begin
        wr_en <= 1'b0;
      end
    end
  end

  AST_WR_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> armed); // R3
  AST_FREEZE_STOPS_WR: assert property (@(posedge clk) disable iff (!rst_n)
    fld_strobe && !save_clr |=> !wr_en && !armed); // R3
  AST_BLOCKED_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    fld_strobe && save_clr && !no_win |=> !wr_en && $stable(vcount)); // R4
  AST_CLEAR_TO_SLOT0: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> wr_en && wr_slot == '0 && vcount == CNT_W'(1)); // R2
  AST_VCOUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    vcount <= FULL); // R2
  AST_WR_QUIET_OFF_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !fld_strobe |=> $stable(wr_en) && $stable(wr_slot) && $stable(wr_busy)); // R9
endmodule

// File: rtl/frs_replay.sv
module frs_replay
  import frs_pkg::*;
#(
  parameter int SLOTS = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       fld_strobe,
  input  logic                       replay_go,
  input  logic                       arm_next,
  input  logic                       armed,
  input  logic [$clog2(SLOTS)-1:0]   wptr,
  input  logic [$clog2(SLOTS+1)-1:0] vcount,
  input  code_t                      acq_lat,
  input  code_t                      pb_code,
  output logic                       replay_active,
  output logic [$clog2(SLOTS)-1:0]   rd_slot
);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int CNT_W  = $clog2(SLOTS + 1);
  localparam logic [SLOT_W:0]  SLOTS_X = (SLOT_W + 1)'(SLOTS);
  localparam logic [CNT_W-1:0] FULL    = CNT_W'(SLOTS);

  logic [SLOT_W-1:0] idx_q;
  logic [HOLD_W-1:0] hold_q;
  logic [HOLD_W-1:0] hold_lim;
  code_t             pb_q;
  logic [SLOT_W-1:0] oldest;
  logic              hold_done;
  logic              last_slot;
  logic              start_evt;

  function automatic logic [SLOT_W-1:0] slot_add(input logic [SLOT_W-1:0] a,
                                                 input logic [SLOT_W:0] b);
    logic [SLOT_W:0] s;
    s = {1'b0, a} + b;
    if (s >= SLOTS_X) s = s - SLOTS_X;
    return s[SLOT_W-1:0];
  endfunction

  always_comb begin
    oldest    = (vcount == FULL) ? wptr : '0;
    hold_lim  = hold_len(acq_lat, pb_q);
    hold_done = (hold_q == hold_lim - 1'b1);
    last_slot = (CNT_W'(idx_q) == vcount - 1'b1);
    start_evt = fld_strobe & ~arm_next & ~replay_active & replay_go & (vcount != '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      replay_active <= 1'b0;
      idx_q         <= '0;
      hold_q        <= '0;
      pb_q          <= '0;
      rd_slot       <= '0;
    end else if (fld_strobe) begin
      if (arm_next) begin
        replay_active <= 1'b0;
      end else if (replay_active) begin
        if (hold_done) begin
          hold_q <= '0;
          if (last_slot) begin
            replay_active <= 1'b0;
          end else begin
            idx_q   <= idx_q + 1'b1;
            rd_slot <= slot_add(oldest, {1'b0, idx_q} + 1'b1);
          end
        end else begin
          hold_q <= hold_q + 1'b1;
        end
      end else if (start_evt) begin
        replay_active <= 1'b1;
        idx_q         <= '0;
        hold_q        <= '0;
        pb_q          <= pb_code;
        rd_slot       <= oldest;
      end
    end
  end

  AST_NO_REPLAY_WHILE_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    replay_active |-> !armed); // R12
  AST_START_AT_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> replay_active && rd_slot == $past(oldest)); // R5
  AST_HOLD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    replay_active |-> hold_q < hold_lim); // R6
  AST_ONLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    replay_active |-> CNT_W'(idx_q) < vcount); // R7
  AST_RD_QUIET_OFF_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !fld_strobe |=> $stable(replay_active) && $stable(rd_slot)); // R9
endmodule

// File: rtl/fld_replay_seq.sv
module fld_replay_seq
  import frs_pkg::*;
#(
  parameter int SLOTS = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fld_strobe,
  input  logic [1:0]               acq_code,
  input  logic [1:0]               pb_code,
  input  logic                     save_clr,
  input  logic                     no_win,
  input  logic                     replay_go,
  output logic                     wr_en,
  output logic [$clog2(SLOTS)-1:0] wr_slot,
  output logic [$clog2(SLOTS)-1:0] rd_slot,
  output logic                     replay_active,
  output logic                     wr_busy
);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int CNT_W  = $clog2(SLOTS + 1);

  logic              arm_next;
  logic              armed;
  logic [SLOT_W-1:0] wptr;
  logic [CNT_W-1:0]  vcount;
  code_t             acq_lat;

  frs_capture #(.SLOTS(SLOTS)) u_capture (
    .clk        (clk),
    .rst_n      (rst_n),
    .fld_strobe (fld_strobe),
    .save_clr   (save_clr),
    .no_win     (no_win),
    .acq_code   (acq_code),
    .arm_next   (arm_next),
    .armed      (armed),
    .wr_en      (wr_en),
    .wr_slot    (wr_slot),
    .wptr       (wptr),
    .vcount     (vcount),
    .acq_lat    (acq_lat),
    .wr_busy    (wr_busy)
  );

  frs_replay #(.SLOTS(SLOTS)) u_replay (
    .clk           (clk),
    .rst_n         (rst_n),
    .fld_strobe    (fld_strobe),
    .replay_go     (replay_go),
    .arm_next      (arm_next),
    .armed         (armed),
    .wptr          (wptr),
    .vcount        (vcount),
    .acq_lat       (acq_lat),
    .pb_code       (pb_code),
    .replay_active (replay_active),
    .rd_slot       (rd_slot)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> !replay_active && !wr_en && !wr_busy); // R10
endmodule

// File: tb/fld_replay_seq_bench.sv
module fld_replay_seq_bench;
  localparam int S = 8;
  localparam int SW = $clog2(S);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fld_strobe = 1'b0;
  logic [1:0] acq_code = '0, pb_code = '0;
  logic save_clr = 1'b0, no_win = 1'b1, replay_go = 1'b0;
  logic wr_en, replay_active, wr_busy;
  logic [SW-1:0] wr_slot, rd_slot;

  always #4 clk = ~clk;

  fld_replay_seq #(.SLOTS(S)) u_fld_replay_seq (
    .clk(clk), .rst_n(rst_n), .fld_strobe(fld_strobe), .acq_code(acq_code),
    .pb_code(pb_code), .save_clr(save_clr), .no_win(no_win), .replay_go(replay_go),
    .wr_en(wr_en), .wr_slot(wr_slot), .rd_slot(rd_slot),
    .replay_active(replay_active), .wr_busy(wr_busy));

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int scramble = 0;

  // expected-state model, built from the requirements
  int m_armed, m_dec, m_wptr, m_vcnt, m_acq, m_wr, m_wslot, m_busy;
  int m_act, m_idx, m_hold, m_pb, m_rd;

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic model_reset();
    m_armed = 0; m_dec = 0; m_wptr = 0; m_vcnt = 0; m_acq = 0; m_wr = 0;
    m_wslot = 0; m_busy = 0; m_act = 0; m_idx = 0; m_hold = 0; m_pb = 0; m_rd = 0;
  endtask

  task automatic model_step(input int s, input int nw, input int a, input int p, input int g);
    int arm, wr_prev, r, old, len;
    arm = s & nw;
    wr_prev = m_wr;
    m_busy = arm && (!m_armed || (m_busy && !wr_prev));
    if (arm) begin
      if (!m_armed) begin m_wptr = 0; m_vcnt = 0; m_dec = 0; end
      m_acq = a;
      r = 4 + 2 * a;
      if (m_dec == 0) begin
        m_wr = 1; m_wslot = m_wptr; m_wptr = (m_wptr + 1) % S;
        if (m_vcnt < S) m_vcnt++;
      end else m_wr = 0;
      m_dec = (m_dec >= r - 1) ? 0 : m_dec + 1;
      m_act = 0;
    end else begin
      m_wr = 0;
      old = (m_vcnt == S) ? m_wptr : 0;
      if (m_act) begin
        len = (4 + 2 * m_acq) << m_pb;
        if (m_hold == len - 1) begin
          m_hold = 0;
          if (m_idx == m_vcnt - 1) m_act = 0;
          else begin m_idx++; m_rd = (old + m_idx) % S; end
        end else m_hold++;
      end else if (g && m_vcnt > 0) begin
        m_act = 1; m_idx = 0; m_hold = 0; m_pb = p; m_rd = old;
      end
    end
    m_armed = arm;
  endtask

  task automatic cmp_all();
    chk("R1 wr_en", int'(wr_en), m_wr);
    if (m_wr) chk("R2 wr_slot", int'(wr_slot), m_wslot);
    chk("R7 replay_active", int'(replay_active), m_act);
    if (m_act) chk("R5 rd_slot", int'(rd_slot), m_rd);
    chk("R11 wr_busy", int'(wr_busy), m_busy);
  endtask

  // one field: strobe with given controls, then two idle cycles of scrambled inputs
  task automatic field(input int s, input int nw, input int a, input int p, input int g);
    @(negedge clk);
    save_clr = 1'(s); no_win = 1'(nw); acq_code = 2'(a); pb_code = 2'(p); replay_go = 1'(g);
    fld_strobe = 1'b1;
    @(negedge clk);
    fld_strobe = 1'b0;
    model_step(s, nw, a, p, g);
    cmp_all();
    for (int k = 0; k < 2; k++) begin
      scramble = scramble * 5 + 3;
      {save_clr, no_win, replay_go, acq_code, pb_code} = 7'(scramble);
      @(negedge clk);
      if (k == 1) begin
        chk("R9 idle wr_en", int'(wr_en), m_wr);
        chk("R9 idle replay_active", int'(replay_active), m_act);
        if (m_act) chk("R9 idle rd_slot", int'(rd_slot), m_rd);
      end
    end
  endtask

  task automatic run_replay_measure(input int p, output int len);
    len = 0;
    field(0, 1, 3 - m_acq, p, 1);
    while (replay_active && len < 2000) begin
      len++;
      field(0, 1, 3 - m_acq, p, 0);
    end
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    int len, writes, nv, nf;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset replay_active", int'(replay_active), 0);
    chk("R10 reset wr_en", int'(wr_en), 0);
    chk("R10 reset wr_busy", int'(wr_busy), 0);
    field(0, 1, 0, 0, 1);
    chk("R10 replay ignored when empty", int'(replay_active), 0);

    // basic capture at ratio 4, partial fill of 3 slots
    for (int f = 0; f < 12; f++) field(1, 1, 0, 0, 0);
    field(0, 1, 0, 0, 0);
    chk("R3 freeze no write", int'(wr_en), 0);
    run_replay_measure(0, len);
    chk("R7 partial replay length", len, 3 * 4);

    // sweep all acquire and playback codes, wrapping the store
    for (int a = 0; a < 4; a++) begin
      for (int p = 0; p < 4; p++) begin
        nf = (4 + 2 * a) * 10 + 1;
        for (int f = 0; f < nf; f++) field(1, 1, a, p, 0);
        field(0, 1, a, p, 0);
        chk("R3 frozen", int'(wr_en), 0);
        field(0, 1, 3 - a, p, 0); // acquire code changes while frozen
        writes = (nf + (4 + 2 * a) - 1) / (4 + 2 * a);
        nv = (writes > S) ? S : writes;
        run_replay_measure(p, len);
        chk("R6 R8 replay length", len, nv * ((4 + 2 * a) << p));
      end
    end

    // blocked arm request keeps content
    for (int f = 0; f < 5; f++) begin
      field(1, 0, 1, 0, 0);
      chk("R4 blocked arm no write", int'(wr_en), 0);
    end
    run_replay_measure(1, len);
    chk("R4 content kept", len, S * (10 << 1));

    // arming during playback aborts it
    field(0, 1, 0, 0, 1);
    field(0, 1, 0, 0, 0);
    chk("R12 replay running", int'(replay_active), 1);
    field(1, 1, 2, 0, 0);
    chk("R12 arm aborts replay", int'(replay_active), 0);
    chk("R2 restart at slot 0", int'(wr_slot), 0);
    chk("R11 busy after arm", int'(wr_busy), 1);
    field(1, 1, 2, 0, 0);
    chk("R11 busy cleared", int'(wr_busy), 0);
    field(0, 1, 2, 0, 0);
    run_replay_measure(2, len);
    chk("R7 single slot replay", len, 8 << 2);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule